// File: doc/BRIEF.md
# Dual Wiper Register File with Access Control

This block is the register space that sits behind a serial slave engine and
serves two 8-bit digital potentiometer channels. It holds a live (volatile)
wiper code for each channel, a bank of eight non-volatile bytes kept as flops,
and a volatile mode byte. The non-volatile bank holds the power-on wiper codes
for channels 0 and 1 at addresses 0 and 1, five free bytes at 2 to 6, and a
spare byte at 7 that is never written. The mode byte sits at address 8.

The engine loads an address pointer, then either writes one data byte at that
pointer or reads bytes from it, advancing the pointer after each byte it sends.
Addresses 0 and 1 each reach two places: the mode byte decides whether a read
returns the stored start-up code or the live wiper code, and whether a write
lands in both or in the wiper alone. A stored start-up code can never change
without the live wiper taking the same value. The block marks a pending
non-volatile commit when a write touches the bank, and turns it into a one-cycle
commit pulse when the engine reports the end of the transfer. The two wiper codes
leave the block as plain buses for the resistor ladder.

Top module: `wiper_regfile`

## Requirements
- R1: After reset both wiper codes and both stored start-up codes are 80h, bytes 2 to 7 of the bank are 00h, the mode byte is 00h, the pointer is 0, and no commit is pending or signalled.
- R2: With mode 00h, a read at address 0 or 1 returns that channel's stored start-up code, and a write there sets both the stored code and the live wiper of that channel to the data.
- R3: With mode 80h, a read at address 0 or 1 returns the live wiper code, and a write there changes only the live wiper; the stored code keeps its value, visible once mode returns to 00h.
- R4: The free bytes at 2 to 6 are read and written with mode 00h; with mode 80h writes to them are dropped and reads return 00h.
- R5: A write to address 8 of exactly 00h or 80h sets the mode; any other value leaves the mode unchanged. A read of address 8 returns the current mode byte.
- R6: Writes to address 7 and to addresses 9 to 15 change nothing, and reads there return 00h.
- R7: A pointer load sets the pointer to the given 4-bit address and takes priority over an advance; an advance steps the pointer by one, and from any address of 8 or more it goes to 0. Writes do not move the pointer. Read data reflects the pointer and state after the clock edge that set them.
- R8: A write that stores into the bank (address 0 to 6 with mode 00h) sets the pending flag on the next cycle; an end-of-transfer strobe clears the flag on the next cycle and, when a commit was pending or stored in that same cycle, raises the commit output for exactly that one cycle. Wiper-only and mode writes set nothing.
- R9: Each wiper output carries its channel's live code unchanged: 00h selects the tap nearest the low terminal and FFh the tap nearest the high terminal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_load | input | 1 | Load the pointer from ptr_addr |
| ptr_addr | input | 4 | Address for a pointer load |
| rd_next | input | 1 | Advance the pointer after a byte was sent |
| wr_en | input | 1 | Write wr_data at the current pointer |
| wr_data | input | 8 | Write data |
| xfer_end | input | 1 | End-of-transfer strobe from the engine |
| rd_data | output | 8 | Byte at the current pointer |
| nv_pending | output | 1 | A non-volatile commit is waiting for the end of the transfer |
| nv_commit | output | 1 | One-cycle request to start the non-volatile commit |
| wiper0 | output | 8 | Live wiper code, channel 0 |
| wiper1 | output | 8 | Live wiper code, channel 1 |

## Verification
The bench builds the block with its default values: 8-bit data, an eight-byte
bank and therefore a 4-bit pointer. That pointer width lets the bench load
addresses 9 to 15, past the mode byte, so the wrap of the advance from those
addresses and the silence of reads and writes there are reached directly.
Both mode settings are driven, including illegal mode values, wiper-only writes
that are later read back through the stored codes, and end-of-transfer strobes
that coincide with a storing write.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    parameter int DW        = 8;
    parameter int NV_BYTES  = 8;
    parameter int N_CH      = 2;

    localparam int AW        = $clog2(NV_BYTES + 1);
    localparam int NV_AW     = $clog2(NV_BYTES);
    localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int CTRL_ADDR = NV_BYTES;
    localparam int RSVD_ADDR = NV_BYTES - 1;
    localparam logic [DW-1:0] WIPER_DEFAULT = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] MODE_LIVE     = DW'(1) << (DW - 1);

    typedef enum logic [1:0] {
        SLOT_IVR  = 2'd0,
        SLOT_GP   = 2'd1,
        SLOT_CTRL = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        slot_e           kind;
        logic [CH_W-1:0] ch;
    } slot_t;

    typedef struct packed {
        logic [N_CH-1:0]  we_wiper;
        logic             we_nv;
        logic [NV_AW-1:0] nv_idx;
        logic             we_mode;
        logic             mode_val;
        logic [DW-1:0]    data;
    } wr_cmd_t;

    function automatic slot_t decode_slot(input logic [AW-1:0] a);
        slot_t s;
        s.kind = SLOT_NONE;
        s.ch   = '0;
        if (int'(a) < N_CH) begin
            s.kind = SLOT_IVR;
            s.ch   = CH_W'(a);
        end else if (int'(a) < RSVD_ADDR) begin
            s.kind = SLOT_GP;
        end else if (int'(a) == CTRL_ADDR) begin
            s.kind = SLOT_CTRL;
        end
        return s;
    endfunction

endpackage

// File: rtl/wrf_ptr.sv
module wrf_ptr
    import wrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_addr;
        end else if (adv) begin
            if (ptr_q >= AW'(CTRL_ADDR)) ptr_q <= '0;
            else                         ptr_q <= ptr_q + AW'(1);
        end
    end

    assign ptr = ptr_q;

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ptr_q >= AW'(CTRL_ADDR)) |=> (ptr_q == '0));

    // R7
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (ptr_q == $past(load_addr)));

endmodule

// File: rtl/wrf_access.sv
module wrf_access
    import wrf_pkg::*;
(
    input  logic                          mode_live,
    input  logic [AW-1:0]                 ptr,
    input  logic                          wr_en,
    input  logic [DW-1:0]                 wr_data,
    input  logic [N_CH-1:0][DW-1:0]       wiper_q,
    input  logic [NV_BYTES-1:0][DW-1:0]   nv_q,
    output wr_cmd_t                       cmd,
    output logic [DW-1:0]                 rd_data
);

    slot_t            slot;
    logic [NV_AW-1:0] idx;

    assign slot = decode_slot(ptr);
    assign idx  = NV_AW'(ptr);

    always_comb begin
        rd_data = '0;
        unique case (slot.kind)
            SLOT_IVR:  rd_data = mode_live ? wiper_q[slot.ch] : nv_q[idx];
            SLOT_GP:   rd_data = mode_live ? '0 : nv_q[idx];
            SLOT_CTRL: rd_data = mode_live ? MODE_LIVE : '0;
            default:   rd_data = '0;
        endcase
    end

    always_comb begin
        cmd          = '0;
        cmd.nv_idx   = idx;
        cmd.data     = wr_data;
        if (wr_en) begin
            unique case (slot.kind)
                SLOT_IVR: begin
                    cmd.we_wiper[slot.ch] = 1'b1;
                    cmd.we_nv             = !mode_live;
                end
                SLOT_GP: begin
                    cmd.we_nv = !mode_live;
                end
                SLOT_CTRL: begin
                    if (wr_data == '0 || wr_data == MODE_LIVE) begin
                        cmd.we_mode  = 1'b1;
                        cmd.mode_val = (wr_data == MODE_LIVE);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wrf_store.sv
module wrf_store
    import wrf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  wr_cmd_t                       cmd,
    output logic                          mode_live,
    output logic [N_CH-1:0][DW-1:0]       wiper_q,
    output logic [NV_BYTES-1:0][DW-1:0]   nv_q
);

    logic mode_q;

    always_ff @(posedge clk) begin
        if (rst)              mode_q <= 1'b0;
        else if (cmd.we_mode) mode_q <= cmd.mode_val;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_wiper
        always_ff @(posedge clk) begin
            if (rst)                  wiper_q[c] <= WIPER_DEFAULT;
            else if (cmd.we_wiper[c]) wiper_q[c] <= cmd.data;
        end
    end

    for (genvar i = 0; i < NV_BYTES; i++) begin : g_nv
        localparam logic [DW-1:0] INIT = (i < N_CH) ? WIPER_DEFAULT : '0;
        if (i == RSVD_ADDR) begin : g_rsvd
            always_ff @(posedge clk) nv_q[i] <= INIT;
        end else begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    nv_q[i] <= INIT;
                else if (cmd.we_nv && cmd.nv_idx == NV_AW'(i))
                    nv_q[i] <= cmd.data;
            end
        end
    end

    assign mode_live = mode_q;

    // R3
    live_mode_nv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !cmd.we_mode) |=> $stable(nv_q));

endmodule

// File: rtl/wrf_commit.sv
module wrf_commit (
    input  logic clk,
    input  logic rst,
    input  logic nv_write,
    input  logic xfer_end,
    output logic pending,
    output logic commit
);

    logic pending_q;
    logic commit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
            commit_q  <= 1'b0;
        end else begin
            commit_q  <= xfer_end && (pending_q || nv_write);
            pending_q <= !xfer_end && (pending_q || nv_write);
        end
    end

    assign pending = pending_q;
    assign commit  = commit_q;

    // R8
    end_clears_pending_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> !pending_q);

    // R8
    commit_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> $past(xfer_end));

    // R8
    store_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (nv_write && !xfer_end) |=> pending_q);

endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile
    import wrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_addr,
    input  logic          rd_next,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          xfer_end,
    output logic [DW-1:0] rd_data,
    output logic          nv_pending,
    output logic          nv_commit,
    output logic [DW-1:0] wiper0,
    output logic [DW-1:0] wiper1
);

    logic [AW-1:0]               ptr;
    logic                        mode_live;
    logic [N_CH-1:0][DW-1:0]     wiper_q;
    logic [NV_BYTES-1:0][DW-1:0] nv_q;
    wr_cmd_t                     cmd;

    wrf_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_addr (ptr_addr),
        .adv       (rd_next),
        .ptr       (ptr)
    );

    wrf_access u_access (
        .mode_live (mode_live),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wiper_q   (wiper_q),
        .nv_q      (nv_q),
        .cmd       (cmd),
        .rd_data   (rd_data)
    );

    wrf_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .mode_live (mode_live),
        .wiper_q   (wiper_q),
        .nv_q      (nv_q)
    );

    wrf_commit u_commit (
        .clk      (clk),
        .rst      (rst),
        .nv_write (cmd.we_nv),
        .xfer_end (xfer_end),
        .pending  (nv_pending),
        .commit   (nv_commit)
    );

    assign wiper0 = wiper_q[0];
    assign wiper1 = wiper_q[1];

    // R6
    dead_addr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (ptr == AW'(RSVD_ADDR) || ptr > AW'(CTRL_ADDR)))
        |=> ($stable(nv_q) && $stable(wiper_q) && $stable(mode_live)));

    // R5
    bad_mode_value_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr == AW'(CTRL_ADDR) && wr_data != '0 && wr_data != MODE_LIVE)
        |=> $stable(mode_live));

    // R2
    stored_write_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mode_live && ptr == '0) |=> (wiper0 == nv_q[0]));

endmodule

// File: tb/wiper_regfile_tb.sv
`timescale 1ns/1ps
module wiper_regfile_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ptr_load = 1'b0;
    logic [3:0] ptr_addr = '0;
    logic       rd_next = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       xfer_end = 1'b0;
    logic [7:0] rd_data;
    logic       nv_pending;
    logic       nv_commit;
    logic [7:0] wiper0;
    logic [7:0] wiper1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wiper_regfile u_dut (
        .clk(clk), .rst(rst), .ptr_load(ptr_load), .ptr_addr(ptr_addr),
        .rd_next(rd_next), .wr_en(wr_en), .wr_data(wr_data),
        .xfer_end(xfer_end), .rd_data(rd_data), .nv_pending(nv_pending),
        .nv_commit(nv_commit), .wiper0(wiper0), .wiper1(wiper1)
    );

    // Behavioural reference model
    logic [7:0] m_nv [0:7];
    logic [7:0] m_wip [0:1];
    bit m_live, m_pend, m_commit, m_store;
    int m_ptr;

    function automatic logic [7:0] m_read(input int p);
        if (p < 2)  return m_live ? m_wip[p] : m_nv[p];
        if (p < 7)  return m_live ? 8'h00 : m_nv[p];
        if (p == 8) return m_live ? 8'h80 : 8'h00;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_nv[i] = 8'h00;
            m_nv[0] = 8'h80; m_nv[1] = 8'h80;
            m_wip[0] = 8'h80; m_wip[1] = 8'h80;
            m_live = 0; m_pend = 0; m_commit = 0; m_ptr = 0;
        end else begin
            m_store = 0;
            if (wr_en) begin
                if (m_ptr < 2) begin
                    m_wip[m_ptr] = wr_data;
                    if (!m_live) begin m_nv[m_ptr] = wr_data; m_store = 1; end
                end else if (m_ptr < 7) begin
                    if (!m_live) begin m_nv[m_ptr] = wr_data; m_store = 1; end
                end else if (m_ptr == 8) begin
                    if (wr_data == 8'h00) m_live = 0;
                    else if (wr_data == 8'h80) m_live = 1;
                end
            end
            m_commit = xfer_end && (m_pend || m_store);
            m_pend   = !xfer_end && (m_pend || m_store);
            if (ptr_load)     m_ptr = int'(ptr_addr);
            else if (rd_next) m_ptr = (m_ptr >= 8) ? 0 : m_ptr + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 rd_data vs model", rd_data, m_read(m_ptr));
            check("R9 wiper0 vs model", wiper0, m_wip[0]);
            check("R9 wiper1 vs model", wiper1, m_wip[1]);
            check("R8 pending vs model", nv_pending, m_pend);
            check("R8 commit vs model", nv_commit, m_commit);
        end
    end

    task automatic load(input int a);
        ptr_load = 1; ptr_addr = 4'(a);
        @(negedge clk);
        ptr_load = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic nxt();
        rd_next = 1;
        @(negedge clk);
        rd_next = 0;
    endtask

    task automatic fin();
        xfer_end = 1;
        @(negedge clk);
        xfer_end = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data at 0", rd_data, 8'h80);
        check("R1 wiper0", wiper0, 8'h80);
        check("R1 wiper1", wiper1, 8'h80);
        check("R1 pending", nv_pending, 0);
        load(8);
        check("R1 mode byte", rd_data, 8'h00);
        load(4);
        check("R1 free byte", rd_data, 8'h00);

        // R2 stored-mode write to channel 0
        load(0); wr(8'h3C);
        check("R9 wiper0 code", wiper0, 8'h3C);
        check("R2 stored code read", rd_data, 8'h3C);
        check("R8 pending set", nv_pending, 1);
        fin();
        check("R8 commit pulse", nv_commit, 1);
        check("R8 pending cleared", nv_pending, 0);
        @(negedge clk);
        check("R8 commit one cycle", nv_commit, 0);

        // R5 enter live mode
        load(8); wr(8'h80);
        check("R5 mode readback", rd_data, 8'h80);
        // R3 wiper-only write
        load(1); wr(8'h0F);
        check("R3 wiper1 live", wiper1, 8'h0F);
        check("R3 live read", rd_data, 8'h0F);
        check("R8 no pending on wiper-only", nv_pending, 0);
        // R4 free bytes hidden in live mode
        load(3); wr(8'h55);
        check("R4 live free read", rd_data, 8'h00);
        // R5 illegal mode value
        load(8); wr(8'h42);
        check("R5 illegal ignored", rd_data, 8'h80);
        wr(8'h00);
        check("R5 back to stored", rd_data, 8'h00);
        load(1);
        check("R3 stored code kept", rd_data, 8'h80);
        check("R3 wiper1 kept", wiper1, 8'h0F);
        load(3);
        check("R4 dropped live write", rd_data, 8'h00);
        wr(8'hA5);
        check("R4 free byte write", rd_data, 8'hA5);
        check("R8 free byte pending", nv_pending, 1);
        // R8 end strobe coinciding with a storing write
        fin();
        load(6); wr_en = 1; wr_data = 8'h66; xfer_end = 1;
        @(negedge clk);
        wr_en = 0; xfer_end = 0;
        check("R8 same-cycle commit", nv_commit, 1);
        check("R8 same-cycle pending", nv_pending, 0);

        // R6 dead addresses
        load(7); wr(8'h77);
        check("R6 reserved read", rd_data, 8'h00);
        check("R8 reserved no pending", nv_pending, 0);
        load(12); wr(8'h12);
        check("R6 high address read", rd_data, 8'h00);
        // R7 wrap
        nxt();
        check("R7 wrap from 12", rd_data, 8'h3C);
        load(6);
        check("R7 load 6", rd_data, 8'h66);
        nxt();
        check("R7 step to 7", rd_data, 8'h00);
        nxt(); nxt();
        check("R7 wrap after 8", rd_data, 8'h3C);
        // R7 load beats advance
        ptr_load = 1; ptr_addr = 4'd3; rd_next = 1;
        @(negedge clk);
        ptr_load = 0; rd_next = 0;
        check("R7 load priority", rd_data, 8'hA5);

        // R9 end codes
        load(0); wr(8'hFF);
        check("R9 wiper0 top", wiper0, 8'hFF);
        load(1); wr(8'h00);
        check("R9 wiper1 bottom", wiper1, 8'h00);

        // Random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            int op = $urandom % 6;
            int sel = $urandom % 4;
            ptr_load = (op == 0);
            ptr_addr = 4'($urandom);
            rd_next  = (op == 1) || (op == 5 && sel == 0);
            wr_en    = (op == 2) || (op == 3);
            wr_data  = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h80 : 8'($urandom);
            xfer_end = (op == 4);
            @(negedge clk);
        end
        ptr_load = 0; rd_next = 0; wr_en = 0; xfer_end = 0;
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule